// File: doc/BRIEF.md
# Circular-Pointer Push-Down Stack

A fixed-depth last-in first-out store for a stack-machine core. The newest item sits in its own register (`top_o`) in front of a small array of spill cells. The array position that holds the item just below the top is marked by a one-hot ring pointer. On a push the ring shifts one place left, on a pop it shifts one place right, and it wraps at both ends. The item below the top (`next_o`) is read combinationally from the cell the pointer selects. Every operation completes on one rising clock edge.

The same block can serve as a data stack, where two-operand operations consume the second item, or as a return stack. There is no overflow or underflow detection. Pushing beyond the depth overwrites the oldest spilled item. Popping past the bottom returns whatever the selected cell still holds.

The decoder turns the three control inputs into one of five named operations, with this priority:
- `OP_REPL` when push and pop are both high (repl ignored).
- `OP_PUSH` when push is high alone.
- `OP_FOLD` when pop and repl are high.
- `OP_DROP` when pop is high alone.
- `OP_REPL` when repl is high alone.
- `OP_HOLD` otherwise.

The operations act as follows:
- `OP_PUSH` spills the top into the cell above the pointer, rotates the pointer left and loads the write data.
- `OP_DROP` moves the second item into the top and rotates the pointer right.
- `OP_FOLD` loads the write data and rotates the pointer right.
- `OP_REPL` loads the write data and leaves the pointer alone.
- `OP_HOLD` changes nothing.

Top module: `stk_pushdown`

## Requirements
- R1: After reset the top register reads 0 and the ring pointer marks cell 0.
- R2: A push (push_i=1, pop_i=0) makes top_o equal the write data and next_o equal the previous top_o, one edge later.
- R3: A pop alone (pop_i=1, push_i=0, repl_i=0) makes top_o equal the previous next_o and next_o the item below it, one edge later.
- R4: Replace (repl_i=1 alone) loads the write data into top_o and leaves next_o and the depth unchanged.
- R5: push_i and pop_i high together act as replace: top_o takes the write data, next_o and the depth are unchanged, and repl_i has no effect. push_i with repl_i acts as a plain push.
- R6: pop_i with repl_i (a two-operand result) makes top_o equal the write data and next_o the item two below the previous top.
- R7: With no control input high, top_o and next_o keep their values.
- R8: Sixteen pushes followed by sixteen pops return the pushed items in reverse order.
- R9: The pointer wraps silently. After 17 pushes from reset, the 17th pop returns the 16th pushed item, which has overwritten the oldest cell. No error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push write data |
| pop_i | input | 1 | Pop the top item |
| repl_i | input | 1 | Replace the top with write data |
| wdata_i | input | 18 | Write data |
| top_o | output | 18 | Top item (registered) |
| next_o | output | 18 | Item below the top (read from the spill cell at the pointer) |

## Verification
Both outputs are due on the first rising edge after an operation is presented. `top_o` is a register, and `next_o` follows the pointer register and the cells, which all update on that same edge. The driver presents each operation at a falling edge and records the expected pair only after the following rising edge. The monitor compares at the next falling edge, half a period after the results settle. `next_o` is compared only when the reference has written the selected cell since reset, because the spill cells are not reset.

// File: rtl/stk_pkg.sv
`timescale 1ns/1ps
package stk_pkg;
    typedef enum logic [2:0] {
        OP_HOLD = 3'd0,
        OP_PUSH = 3'd1,
        OP_DROP = 3'd2,
        OP_REPL = 3'd3,
        OP_FOLD = 3'd4
    } stk_op_e;
endpackage

// File: rtl/stk_op_decode.sv
`timescale 1ns/1ps
module stk_op_decode
    import stk_pkg::*;
(
    input  logic    push_i,
    input  logic    pop_i,
    input  logic    repl_i,
    output stk_op_e op_o
);
    always_comb begin
        if (push_i && pop_i)      op_o = OP_REPL;
        else if (push_i)          op_o = OP_PUSH;
        else if (pop_i && repl_i) op_o = OP_FOLD;
        else if (pop_i)           op_o = OP_DROP;
        else if (repl_i)          op_o = OP_REPL;
        else                      op_o = OP_HOLD;
    end
endmodule

// File: rtl/stk_ring_ptr.sv
`timescale 1ns/1ps
module stk_ring_ptr
    import stk_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stk_op_e          op_i,
    output logic [DEPTH-1:0] ptr_o,
    output logic [DEPTH-1:0] ptr_up_o
);
    localparam logic [DEPTH-1:0] PTR_RESET = DEPTH'(1);

    logic [DEPTH-1:0] ptr_q;
    logic [DEPTH-1:0] ptr_dn;

    assign ptr_up_o = {ptr_q[DEPTH-2:0], ptr_q[DEPTH-1]};
    assign ptr_dn   = {ptr_q[0], ptr_q[DEPTH-1:1]};
    assign ptr_o    = ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= PTR_RESET;
        end else begin
            unique case (op_i)
                OP_PUSH:          ptr_q <= ptr_up_o;
                OP_DROP, OP_FOLD: ptr_q <= ptr_dn;
                OP_REPL, OP_HOLD: ptr_q <= ptr_q;
                default:          ptr_q <= ptr_q;
            endcase
        end
    end

    // R9: the ring keeps exactly one marked cell through every wrap
    a_r9_ptr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(ptr_q));

    // R4 / R5: replace never moves the pointer
    a_r4_ptr_still: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_REPL) |=> $stable(ptr_q));

    // R7: idle never moves the pointer
    a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_HOLD) |=> $stable(ptr_q));
endmodule

// File: rtl/stk_spill_ram.sv
`timescale 1ns/1ps
module stk_spill_ram #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             wr_en_i,
    input  logic [DEPTH-1:0] wr_sel_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic [DEPTH-1:0] rd_sel_i,
    output logic [WIDTH-1:0] rd_data_o
);
    logic [DEPTH-1:0][WIDTH-1:0] cell_q;
    logic [DEPTH-1:0][WIDTH-1:0] masked;

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_en_i && wr_sel_i[i]) cell_q[i] <= wr_data_i;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_rd
        assign masked[g] = cell_q[g] & {WIDTH{rd_sel_i[g]}};
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < DEPTH; i++) rd_data_o = rd_data_o | masked[i];
    end
endmodule

// File: rtl/stk_pushdown.sv
`timescale 1ns/1ps
module stk_pushdown
    import stk_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             repl_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] top_o,
    output logic [WIDTH-1:0] next_o
);
    stk_op_e          op;
    logic [DEPTH-1:0] ptr;
    logic [DEPTH-1:0] ptr_up;
    logic [WIDTH-1:0] top_q;
    logic [WIDTH-1:0] below;

    stk_op_decode u_dec (
        .push_i (push_i),
        .pop_i  (pop_i),
        .repl_i (repl_i),
        .op_o   (op)
    );

    stk_ring_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op),
        .ptr_o    (ptr),
        .ptr_up_o (ptr_up)
    );

    stk_spill_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
        .clk       (clk),
        .wr_en_i   (op == OP_PUSH),
        .wr_sel_i  (ptr_up),
        .wr_data_i (top_q),
        .rd_sel_i  (ptr),
        .rd_data_o (below)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            unique case (op)
                OP_PUSH, OP_REPL, OP_FOLD: top_q <= wdata_i;
                OP_DROP:                   top_q <= below;
                OP_HOLD:                   top_q <= top_q;
                default:                   top_q <= top_q;
            endcase
        end
    end

    always_comb begin
        top_o  = top_q;
        next_o = below;
    end

    a_r2_push_spill: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PUSH) |=> (next_o == $past(top_o)));

    a_r2_push_top: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PUSH) |=> (top_o == $past(wdata_i)));

    a_r3_drop_refill: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DROP) |=> (top_o == $past(next_o)));

    a_r4_repl_keeps_next: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_REPL) |=> (next_o == $past(next_o)));

    a_r5_both_is_replace: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> (top_o == $past(wdata_i) && next_o == $past(next_o)));

    a_r6_fold_top: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FOLD) |=> (top_o == $past(wdata_i)));

    a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> ($stable(top_o) && $stable(next_o)));
endmodule

// File: tb/stk_pushdown_tb.sv
`timescale 1ns/1ps
module stk_pushdown_tb;
    localparam int D = 16;
    localparam int W = 18;

    typedef struct {
        logic [W-1:0] top;
        logic [W-1:0] nxt;
        bit           nk;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         push_i = 1'b0, pop_i = 1'b0, repl_i = 1'b0;
    logic [W-1:0] wdata_i = '0;
    logic [W-1:0] top_o, next_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    exp_t q[$];

    // reference model: binary index, independent of the ring encoding
    logic [W-1:0] m_top;
    logic [W-1:0] m_ram [D];
    bit           m_known [D];
    int           m_idx;

    stk_pushdown #(.DEPTH(D), .WIDTH(W)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push_i),
        .pop_i   (pop_i),
        .repl_i  (repl_i),
        .wdata_i (wdata_i),
        .top_o   (top_o),
        .next_o  (next_o)
    );

    always #5 clk = ~clk;

    // monitor: one falling edge after the rising edge that applied the op
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (top_o !== e.top || (e.nk && next_o !== e.nxt)) begin
                errors++;
                $display("FAIL %s top=%h next=%h expected top=%h next=%h%s",
                         e.tag, top_o, next_o, e.top, e.nxt, e.nk ? "" : "(unchecked)");
            end
        end
    end

    task automatic model_reset();
        m_top = '0;
        m_idx = 0;
        for (int i = 0; i < D; i++) m_known[i] = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        @(posedge clk);
        #1 rst_n = 1'b0;
        model_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        checks++;
        if (top_o !== '0) begin
            errors++;
            $display("FAIL R1 top=%h expected top=%h", top_o, {W{1'b0}});
        end
    endtask

    task automatic do_op(input logic p, input logic po, input logic r,
                         input logic [W-1:0] w, input string tag);
        exp_t e;
        @(negedge clk);
        push_i = p; pop_i = po; repl_i = r; wdata_i = w;
        @(posedge clk);
        // reference update from the requirements
        if (p && po)        m_top = w;
        else if (p) begin
            m_idx = (m_idx + 1) % D;
            m_ram[m_idx] = m_top;
            m_known[m_idx] = 1;
            m_top = w;
        end else if (po && r) begin
            m_top = w;
            m_idx = (m_idx + D - 1) % D;
        end else if (po) begin
            m_top = m_ram[m_idx];
            m_idx = (m_idx + D - 1) % D;
        end else if (r)     m_top = w;
        e.top = m_top;
        e.nxt = m_ram[m_idx];
        e.nk  = m_known[m_idx];
        e.tag = tag;
        q.push_back(e);
        #1 push_i = 0; pop_i = 0; repl_i = 0;
    endtask

    function automatic logic [W-1:0] pat(input int i);
        return W'(i * 18'h0159 + 18'h02A5);
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();                                   // R1
        do_op(1, 0, 0, 18'h11111, "R2 push");
        do_op(1, 0, 0, 18'h22222, "R2 push");
        do_op(1, 0, 0, 18'h3ABCD, "R2 push");
        do_op(1, 0, 0, 18'h04444, "R2 push");
        do_op(0, 1, 0, 18'h3FFFF, "R3 pop");
        do_op(0, 0, 1, 18'h15555, "R4 replace");
        do_op(1, 1, 0, 18'h26666, "R5 push+pop");
        do_op(1, 1, 1, 18'h07777, "R5 push+pop+repl");
        do_op(1, 0, 1, 18'h18888, "R5 push+repl is push");
        do_op(0, 1, 1, 18'h29999, "R6 fold");
        do_op(0, 0, 0, 18'h3AAAA, "R7 idle");
        do_op(0, 0, 0, 18'h0BBBB, "R7 idle");
        do_op(0, 1, 0, 18'h00000, "R3 pop");

        do_reset();
        for (int i = 1; i <= D; i++) do_op(1, 0, 0, pat(i), "R8 fill");
        for (int i = 1; i <= D; i++) do_op(0, 1, 0, 18'h00000, "R8 reverse order");

        do_reset();
        for (int i = 1; i <= D + 1; i++) do_op(1, 0, 0, pat(i + 40), "R9 overfill");
        for (int i = 1; i <= D; i++) do_op(0, 1, 0, 18'h00000, "R9 drain");
        do_op(0, 1, 0, 18'h00000, "R9 wrapped pop");

        @(negedge clk);
        @(negedge clk);
        // explicit R9 tail check: 17th pop yields the 16th pushed item
        checks++;
        if (top_o !== pat(D + 40)) begin
            errors++;
            $display("FAIL R9 top=%h expected top=%h", top_o, pat(D + 40));
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule